// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block sequences transfers for a multi-channel DMA controller. A register unit loads each channel's source address, destination address, link pointer, control word and configuration word through a narrow write port. Whenever the block is idle and globally enabled, it picks the lowest-numbered channel that is ready to run. It then moves exactly one element for that channel over a single-beat memory master port, updates the channel's addresses and remaining count, and goes back to scanning.

An element is gathered from the source in chunks of the source width until the destination width is filled. It is then scattered to the destination in chunks of the destination width. When a descriptor's count runs out, the engine does one of two things. If the link pointer is nonzero, it reloads the channel from a four-word descriptor in memory. If the link pointer is zero, it switches the channel off. In both cases it can raise a one-cycle terminal-count pulse. If a memory error response arrives, the channel is dropped and flagged.

The memory port uses valid/ready. A request (`mem_req_*`) is offered by the engine and must be held unchanged until the memory accepts it. Exactly one response beat (`mem_rsp_*`) comes back for every accepted request, reads and writes alike. The engine raises `mem_rsp_ready` only while it waits for that beat. It never has more than one request outstanding.

Top module: `dma_ll_engine`

## Requirements
- R1: A channel can be picked only if its configuration bit 0 (enable) is 1 and bit 18 (halt) is 0. When several channels qualify, the lowest index is served first.
- R2: Configuration bits 13:11 select the flow type. With 0, no request is needed. With 1, the request line numbered by bits 10:6 must be high. With 2, the line numbered by bits 5:1 must be high. With 3, both lines must be high. Types 4 to 7 are never served. A line counts as high if either its single or its burst input is high.
- R3: While `glob_en` is 0 and the engine is idle, no memory request is issued.
- R4: Control bits 20:18 give the source width and bits 23:21 give the destination width, with code 0 for 1 byte, 1 for 2 bytes and 2 or more for 4 bytes. Reads fill a little-endian buffer until the destination width is reached. Writes then cover the larger of the two widths. Byte lanes follow address bits 1:0, `mem_req_be` marks the lanes used, and unused write lanes are zero.
- R5: After each read, the source address advances by the source width if control bit 26 is 1. After each write, the destination address advances by the destination width if control bit 27 is 1.
- R6: Each service moves one element, lowers the count in control bits 11:0 by one, and then returns to scanning from channel 0.
- R7: When the count reaches zero and the link pointer is nonzero, four word reads fetch link+0 into the source address, link+4 into the destination address, link+12 into the control word and link+8 into the link pointer, in that order. The channel stays enabled.
- R8: When the count reaches zero and the link pointer is zero, the channel's enable bit is cleared. A channel picked with a count of zero goes straight to this step without moving any data.
- R9: At the end of a descriptor, `tc_pulse` carries a one-cycle pulse on the channel's bit if bit 31 of that descriptor's control word was 1.
- R10: An error response pulses the channel's `err_pulse` bit for one cycle, clears its enable bit and abandons the service.
- R11: A request stays valid with unchanged fields until `mem_req_ready`. A response is taken when `mem_rsp_valid` and `mem_rsp_ready` are both high.
- R12: After reset, all channels are off and no request or pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| glob_en | input | 1 | Global run enable |
| req_single | input | REQW | Peripheral single-request lines |
| req_burst | input | REQW | Peripheral burst-request lines |
| reg_we | input | 1 | Channel register write strobe |
| reg_chan | input | CW | Channel to write |
| reg_sel | input | 3 | Field: 0 src, 1 dst, 2 link, 3 control, 4 configuration |
| reg_wdata | input | 32 | Write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 32 | Write data on lanes |
| mem_req_be | output | 4 | Byte lane enables |
| mem_rsp_valid | input | 1 | Response beat valid |
| mem_rsp_ready | output | 1 | Engine waits for a response |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Error response |
| chan_on | output | NCH | Enable bit of each channel |
| tc_pulse | output | NCH | Terminal-count pulses |
| err_pulse | output | NCH | Error pulses |
| busy | output | 1 | Engine is serving a channel |

## Verification
The assertions assume two things about the environment. First, the register unit does not write to the channel being served while a service is in progress. Second, every address the engine is given is aligned to the widths it is used with. The stimulus programs channels only while the engine is idle or globally disabled, and it chooses every source, destination and link address to be a multiple of the widths in use. The memory model applies back-pressure on a fixed pattern and returns exactly one response per accepted request, as R11 requires.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;
  localparam int WORD_W = 32;
  localparam int CFG_W  = 19;
  localparam int CFG_EN   = 0;
  localparam int CFG_HALT = 18;
  localparam int CTL_SINC = 26;
  localparam int CTL_DINC = 27;
  localparam int CTL_TCIE = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT, ST_CPL, ST_LL_REQ, ST_LL_WAIT
  } eng_state_t;

  // width code -> byte count (codes above 2 saturate at a full word)
  function automatic logic [2:0] width_bytes(input logic [2:0] code);
    case (code)
      3'd0:    return 3'd1;
      3'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [2:0] nbytes);
    case (nbytes)
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] bit_mask(input logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction
endpackage

// File: rtl/dma_ll_pick.sv
module dma_ll_pick
  import dma_ll_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int REQW = 16,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0][CFG_W-1:0] cfg,
  input  logic [REQW-1:0]           req,
  output logic                      grant_vld,
  output logic [CW-1:0]             grant_idx
);
  logic [31:0]    req_pad;
  logic [NCH-1:0] cand;

  assign req_pad = 32'(req);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [4:0] sid, did;
    logic [2:0] flow;
    logic       gate;
    assign sid  = cfg[g][5:1];
    assign did  = cfg[g][10:6];
    assign flow = cfg[g][13:11];
    always_comb begin
      case (flow)
        3'd0:    gate = 1'b1;
        3'd1:    gate = req_pad[did];
        3'd2:    gate = req_pad[sid];
        3'd3:    gate = req_pad[sid] & req_pad[did];
        default: gate = 1'b0;
      endcase
    end
    assign cand[g] = cfg[g][CFG_EN] & ~cfg[g][CFG_HALT] & gate;
  end

  always_comb begin
    grant_vld = |cand;
    grant_idx = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (cand[i]) grant_idx = CW'(i);
  end
endmodule

// File: rtl/dma_ll_lane.sv
module dma_ll_lane
  import dma_ll_pkg::*;
(
  input  logic [31:0] rdata,
  input  logic [1:0]  rd_lane,
  input  logic [2:0]  rd_bytes,
  input  logic [1:0]  wr_lane,
  input  logic [2:0]  wr_bytes,
  input  logic [2:0]  pos,
  input  logic [31:0] buff,
  output logic [31:0] buff_next,
  output logic [3:0]  rd_be,
  output logic [31:0] wdata,
  output logic [3:0]  wr_be
);
  logic [31:0] rsh, wch;

  always_comb begin
    rsh       = rdata >> {rd_lane, 3'b000};
    buff_next = buff | ((rsh & bit_mask(lane_mask(rd_bytes))) << {pos, 3'b000});
    rd_be     = lane_mask(rd_bytes) << rd_lane;
    wch       = (buff >> {pos, 3'b000}) & bit_mask(lane_mask(wr_bytes));
    wdata     = wch << {wr_lane, 3'b000};
    wr_be     = lane_mask(wr_bytes) << wr_lane;
  end
endmodule

// File: rtl/dma_ll_engine.sv
module dma_ll_engine
  import dma_ll_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int REQW = 16,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            glob_en,
  input  logic [REQW-1:0] req_single,
  input  logic [REQW-1:0] req_burst,
  input  logic            reg_we,
  input  logic [CW-1:0]   reg_chan,
  input  logic [2:0]      reg_sel,
  input  logic [31:0]     reg_wdata,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [31:0]     mem_req_addr,
  output logic [31:0]     mem_req_wdata,
  output logic [3:0]      mem_req_be,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [31:0]     mem_rsp_data,
  input  logic            mem_rsp_err,
  output logic [NCH-1:0]  chan_on,
  output logic [NCH-1:0]  tc_pulse,
  output logic [NCH-1:0]  err_pulse,
  output logic            busy
);
  logic [NCH-1:0][31:0]      src_q, dst_q, lnk_q, ctl_q;
  logic [NCH-1:0][CFG_W-1:0] cfg_q;
  eng_state_t  st;
  logic [CW-1:0] cur;
  logic [2:0]  pos;
  logic [31:0] buff, lbase;
  logic [1:0]  llk;
  logic        tc_flag;

  logic          grant_vld;
  logic [CW-1:0] grant_idx;
  logic [31:0]   cur_ctl, buff_next, lane_wdata, ll_off;
  logic [2:0]    sbytes, dbytes, big, pos_rd, pos_wr;
  logic [3:0]    rd_be, wr_be;
  logic [11:0]   size_dec;

  dma_ll_pick #(.NCH(NCH), .REQW(REQW)) u_pick (
    .cfg(cfg_q), .req(req_single | req_burst),
    .grant_vld(grant_vld), .grant_idx(grant_idx));

  assign cur_ctl  = ctl_q[cur];
  assign sbytes   = width_bytes(cur_ctl[20:18]);
  assign dbytes   = width_bytes(cur_ctl[23:21]);
  assign big      = (sbytes > dbytes) ? sbytes : dbytes;
  assign pos_rd   = pos + sbytes;
  assign pos_wr   = pos + dbytes;
  assign size_dec = cur_ctl[11:0] - 12'd1;

  dma_ll_lane u_lane (
    .rdata(mem_rsp_data), .rd_lane(src_q[cur][1:0]), .rd_bytes(sbytes),
    .wr_lane(dst_q[cur][1:0]), .wr_bytes(dbytes), .pos(pos), .buff(buff),
    .buff_next(buff_next), .rd_be(rd_be), .wdata(lane_wdata), .wr_be(wr_be));

  // descriptor word order: source, destination, control, link
  always_comb begin
    case (llk)
      2'd0:    ll_off = 32'd0;
      2'd1:    ll_off = 32'd4;
      2'd2:    ll_off = 32'd12;
      default: ll_off = 32'd8;
    endcase
  end

  always_comb begin
    mem_req_valid = (st == ST_RD_REQ) || (st == ST_WR_REQ) || (st == ST_LL_REQ);
    mem_req_write = (st == ST_WR_REQ);
    mem_rsp_ready = (st == ST_RD_WAIT) || (st == ST_WR_WAIT) || (st == ST_LL_WAIT);
    mem_req_wdata = (st == ST_WR_REQ) ? lane_wdata : 32'd0;
    case (st)
      ST_RD_REQ: begin mem_req_addr = src_q[cur];      mem_req_be = rd_be;   end
      ST_WR_REQ: begin mem_req_addr = dst_q[cur];      mem_req_be = wr_be;   end
      ST_LL_REQ: begin mem_req_addr = lbase + ll_off;  mem_req_be = 4'hF;    end
      default:   begin mem_req_addr = 32'd0;           mem_req_be = 4'h0;    end
    endcase
  end

  for (genvar g = 0; g < NCH; g++) begin : g_on
    assign chan_on[g] = cfg_q[g][CFG_EN];
  end
  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; lnk_q <= '0; ctl_q <= '0; cfg_q <= '0;
      st <= ST_IDLE; cur <= '0; pos <= '0; buff <= '0; lbase <= '0;
      llk <= '0; tc_flag <= 1'b0; tc_pulse <= '0; err_pulse <= '0;
    end else begin
      tc_pulse  <= '0;
      err_pulse <= '0;
      if (reg_we) begin
        case (reg_sel)
          3'd0: src_q[reg_chan] <= reg_wdata;
          3'd1: dst_q[reg_chan] <= reg_wdata;
          3'd2: lnk_q[reg_chan] <= reg_wdata;
          3'd3: ctl_q[reg_chan] <= reg_wdata;
          3'd4: cfg_q[reg_chan] <= reg_wdata[CFG_W-1:0];
          default: ;
        endcase
      end
      case (st)
        ST_IDLE: if (glob_en && grant_vld) begin
          cur  <= grant_idx;
          pos  <= '0;
          buff <= '0;
          st   <= (ctl_q[grant_idx][11:0] == 12'd0) ? ST_CPL : ST_RD_REQ;
        end
        ST_RD_REQ: if (mem_req_ready) st <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            err_pulse[cur]     <= 1'b1;
            cfg_q[cur][CFG_EN] <= 1'b0;
            st                 <= ST_IDLE;
          end else begin
            buff <= buff_next;
            if (cur_ctl[CTL_SINC]) src_q[cur] <= src_q[cur] + 32'(sbytes);
            if (pos_rd >= dbytes) begin pos <= '0;     st <= ST_WR_REQ; end
            else                  begin pos <= pos_rd; st <= ST_RD_REQ; end
          end
        end
        ST_WR_REQ: if (mem_req_ready) st <= ST_WR_WAIT;
        ST_WR_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            err_pulse[cur]     <= 1'b1;
            cfg_q[cur][CFG_EN] <= 1'b0;
            st                 <= ST_IDLE;
          end else begin
            if (cur_ctl[CTL_DINC]) dst_q[cur] <= dst_q[cur] + 32'(dbytes);
            if (pos_wr >= big) begin
              ctl_q[cur][11:0] <= size_dec;
              st <= (size_dec == 12'd0) ? ST_CPL : ST_IDLE;
            end else begin
              pos <= pos_wr;
              st  <= ST_WR_REQ;
            end
          end
        end
        ST_CPL: begin
          tc_flag <= cur_ctl[CTL_TCIE];
          if (lnk_q[cur] != 32'd0) begin
            lbase <= lnk_q[cur];
            llk   <= 2'd0;
            st    <= ST_LL_REQ;
          end else begin
            cfg_q[cur][CFG_EN] <= 1'b0;
            tc_pulse[cur]      <= cur_ctl[CTL_TCIE];
            st                 <= ST_IDLE;
          end
        end
        ST_LL_REQ: if (mem_req_ready) st <= ST_LL_WAIT;
        ST_LL_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            err_pulse[cur]     <= 1'b1;
            cfg_q[cur][CFG_EN] <= 1'b0;
            st                 <= ST_IDLE;
          end else begin
            case (llk)
              2'd0:    src_q[cur] <= mem_rsp_data;
              2'd1:    dst_q[cur] <= mem_rsp_data;
              2'd2:    ctl_q[cur] <= mem_rsp_data;
              default: lnk_q[cur] <= mem_rsp_data;
            endcase
            if (llk == 2'd3) begin
              tc_pulse[cur] <= tc_flag;
              st            <= ST_IDLE;
            end else begin
              llk <= llk + 2'd1;
              st  <= ST_LL_REQ;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // request fields held under back-pressure
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_be)));

  // no activity starts while globally disabled
  assert_glob_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !busy) |=> !mem_req_valid);

  // a service only begins on an enabled, non-halted channel
  assert_start_cand_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (chan_on[cur] && !cfg_q[cur][CFG_HALT]));

  assert_tc_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_pulse));

  // an errored channel is already off when its pulse is visible
  assert_err_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |-> ((err_pulse & chan_on) == '0));

  assert_rsp_only_waiting_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);
endmodule

// File: tb/dma_ll_engine_bench.sv
module dma_ll_engine_bench;
  localparam int NCH = 4, REQW = 16, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0, glob_en = 1'b0;
  logic [REQW-1:0] req_single = '0, req_burst = '0;
  logic reg_we = 1'b0; logic [CW-1:0] reg_chan = '0; logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic mem_req_valid, mem_req_write, mem_rsp_ready, busy;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_data = '0;
  logic [3:0] mem_req_be;
  logic [NCH-1:0] chan_on, tc_pulse, err_pulse;

  always #10 clk = ~clk;

  dma_ll_engine #(.NCH(NCH), .REQW(REQW)) u_dma_ll_engine (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .req_single(req_single),
    .req_burst(req_burst), .reg_we(reg_we), .reg_chan(reg_chan), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err), .chan_on(chan_on),
    .tc_pulse(tc_pulse), .err_pulse(err_pulse), .busy(busy));

  typedef struct packed {
    logic [7:0]  tag;
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
  } tx_t;

  tx_t exp_q[$];
  int errors = 0, checks = 0, cyc = 0;
  int tc_cnt[NCH], err_cnt[NCH];
  logic [31:0] mem [0:63];
  logic pend = 1'b0, consume = 1'b0, err_en = 1'b0;
  logic [31:0] pend_data = '0, err_addr = '0;
  logic pend_err = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    tx_t e;
    cyc++;
    if (consume) begin mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; consume = 1'b0; end
    if (pend) begin
      mem_rsp_valid = 1'b1; mem_rsp_data = pend_data; mem_rsp_err = pend_err; pend = 1'b0;
    end
    mem_req_ready = (cyc % 3) != 0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected request actual=%h expected=none", mem_req_addr);
      end else begin
        e = exp_q.pop_front();
        if (e.wr !== mem_req_write || e.addr !== mem_req_addr || e.be !== mem_req_be ||
            (e.wr && e.data !== mem_req_wdata)) begin
          errors++;
          $display("FAIL R%0d actual=%b/%h/%h/%b expected=%b/%h/%h/%b", e.tag,
                   mem_req_write, mem_req_addr, mem_req_wdata, mem_req_be,
                   e.wr, e.addr, e.data, e.be);
        end
      end
      pend_err  = err_en && (mem_req_addr == err_addr);
      pend_data = mem[mem_req_addr[7:2]];
      if (mem_req_write)
        for (int b = 0; b < 4; b++)
          if (mem_req_be[b]) mem[mem_req_addr[7:2]][b*8 +: 8] = mem_req_wdata[b*8 +: 8];
      pend = 1'b1;
    end
    if (mem_rsp_valid && mem_rsp_ready) consume = 1'b1;
    for (int i = 0; i < NCH; i++) begin
      tc_cnt[i]  += int'(tc_pulse[i]);
      err_cnt[i] += int'(err_pulse[i]);
    end
  end

  task automatic expect_tx(input int tag, input logic wr, input logic [31:0] a,
                           input logic [31:0] d, input logic [3:0] be);
    exp_q.push_back('{tag: 8'(tag), wr: wr, addr: a, data: d, be: be});
  endtask

  task automatic wreg(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_chan = CW'(ch); reg_sel = 3'(sel); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] l, input logic [31:0] c, input logic [31:0] f);
    wreg(ch, 0, s); wreg(ch, 1, d); wreg(ch, 2, l); wreg(ch, 3, c); wreg(ch, 4, f);
  endtask

  function automatic logic [31:0] ctlw(input logic ie, input logic si, input logic di,
      input logic [2:0] swc, input logic [2:0] dwc, input logic [11:0] n);
    return {ie, 3'b0, di, si, 2'b0, dwc, swc, 6'b0, n};
  endfunction

  function automatic logic [31:0] cfgw(input logic [2:0] flow, input logic [4:0] did,
      input logic [4:0] sid, input logic halt, input logic en);
    return {13'b0, halt, 4'b0, flow, did, sid, en};
  endfunction

  task automatic drain();
    int n = 0;
    repeat (10) @(negedge clk);
    while ((exp_q.size() != 0 || busy) && n < 3000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk("R6 scoreboard drained", 32'(exp_q.size()), 32'd0);
  endtask

  task automatic clr_cnt();
    for (int i = 0; i < NCH; i++) begin tc_cnt[i] = 0; err_cnt[i] = 0; end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++)
      mem[i] = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
    clr_cnt();
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 chan_on", 32'(chan_on), 32'd0);
    chk("R12 tc_pulse", 32'(tc_pulse), 32'd0);
    chk("R12 req_valid", 32'(mem_req_valid), 32'd0);
    rst_n = 1'b1;
    glob_en = 1'b1;
    @(negedge clk);

    // R4 R5 R9: word to word, both increment, two elements, tc on
    expect_tx(4, 0, 32'h10, 0, 4'hF); expect_tx(4, 1, 32'h40, 32'h13121110, 4'hF);
    expect_tx(5, 0, 32'h14, 0, 4'hF); expect_tx(5, 1, 32'h44, 32'h17161514, 4'hF);
    prog(0, 32'h10, 32'h40, 0, ctlw(1, 1, 1, 2, 2, 12'd2), cfgw(0, 0, 0, 0, 1));
    drain();
    chk("R9 tc count ch0", 32'(tc_cnt[0]), 32'd1);
    chk("R8 ch0 off", 32'(chan_on[0]), 32'd0);

    // R4: byte reads gathered into one word write
    clr_cnt();
    expect_tx(4, 0, 32'h21, 0, 4'b0010); expect_tx(4, 0, 32'h22, 0, 4'b0100);
    expect_tx(4, 0, 32'h23, 0, 4'b1000); expect_tx(4, 0, 32'h24, 0, 4'b0001);
    expect_tx(4, 1, 32'h50, 32'h24232221, 4'hF);
    prog(1, 32'h21, 32'h50, 0, ctlw(0, 1, 1, 0, 2, 12'd1), cfgw(0, 0, 0, 0, 1));
    drain();
    chk("R9 no tc when bit31 clear", 32'(tc_cnt[1]), 32'd0);

    // R4 R5: word read, halfword writes, source fixed
    expect_tx(4, 0, 32'h30, 0, 4'hF);
    expect_tx(4, 1, 32'h62, 32'h31300000, 4'b1100);
    expect_tx(5, 1, 32'h64, 32'h00003332, 4'b0011);
    prog(0, 32'h30, 32'h62, 0, ctlw(0, 0, 1, 2, 1, 12'd1), cfgw(0, 0, 0, 0, 1));
    drain();

    // R3 R1 R6: global off, then priority and halt
    clr_cnt();
    glob_en = 1'b0;
    prog(1, 32'h78, 32'h98, 0, ctlw(1, 1, 1, 2, 2, 12'd1), cfgw(0, 0, 0, 0, 1));
    prog(0, 32'h70, 32'h90, 0, ctlw(0, 1, 1, 2, 2, 12'd2), cfgw(0, 0, 0, 0, 1));
    prog(2, 32'h00, 32'hF0, 0, ctlw(0, 1, 1, 2, 2, 12'd1), cfgw(0, 0, 0, 1, 1));
    repeat (20) @(negedge clk);
    chk("R3 no request while disabled", 32'(mem_req_valid), 32'd0);
    chk("R3 channels still on", 32'(chan_on), 32'b0111);
    expect_tx(1, 0, 32'h70, 0, 4'hF); expect_tx(1, 1, 32'h90, 32'h73727170, 4'hF);
    expect_tx(6, 0, 32'h74, 0, 4'hF); expect_tx(6, 1, 32'h94, 32'h77767574, 4'hF);
    expect_tx(1, 0, 32'h78, 0, 4'hF); expect_tx(1, 1, 32'h98, 32'h7B7A7978, 4'hF);
    glob_en = 1'b1;
    drain();
    chk("R9 tc only on ch1", {tc_cnt[1][15:0], tc_cnt[0][15:0]}, 32'h0001_0000);
    chk("R1 halted ch2 stays on", 32'(chan_on), 32'b0100);

    // R2: flow type gating
    prog(0, 32'hA0, 32'hB0, 0, ctlw(0, 0, 0, 2, 2, 12'd1), cfgw(2, 5, 3, 0, 1));
    repeat (30) @(negedge clk);
    chk("R2 flow2 waits for src request", 32'(chan_on[0]), 32'd1);
    expect_tx(2, 0, 32'hA0, 0, 4'hF); expect_tx(2, 1, 32'hB0, 32'hA3A2A1A0, 4'hF);
    req_burst[3] = 1'b1;
    drain();
    req_burst = '0;
    req_single[3] = 1'b1;
    prog(0, 32'hA4, 32'hB4, 0, ctlw(0, 0, 0, 2, 2, 12'd1), cfgw(1, 5, 3, 0, 1));
    repeat (30) @(negedge clk);
    chk("R2 flow1 ignores src request", 32'(chan_on[0]), 32'd1);
    expect_tx(2, 0, 32'hA4, 0, 4'hF); expect_tx(2, 1, 32'hB4, 32'hA7A6A5A4, 4'hF);
    req_single[5] = 1'b1;
    drain();
    prog(0, 32'hA8, 32'hB8, 0, ctlw(0, 0, 0, 2, 2, 12'd1), cfgw(5, 5, 3, 0, 1));
    repeat (30) @(negedge clk);
    chk("R2 flow5 never served", 32'(chan_on[0]), 32'd1);
    req_single = '0;
    wreg(0, 4, 0);

    // R7: linked descriptor reload
    clr_cnt();
    mem[6'h38] = 32'h20; mem[6'h39] = 32'hD8; mem[6'h3A] = 32'h0;
    mem[6'h3B] = ctlw(1, 1, 1, 2, 2, 12'd1);
    expect_tx(7, 0, 32'hC0, 0, 4'hF); expect_tx(7, 1, 32'hD0, 32'hC3C2C1C0, 4'hF);
    expect_tx(7, 0, 32'hE0, 0, 4'hF); expect_tx(7, 0, 32'hE4, 0, 4'hF);
    expect_tx(7, 0, 32'hEC, 0, 4'hF); expect_tx(7, 0, 32'hE8, 0, 4'hF);
    expect_tx(7, 0, 32'h20, 0, 4'hF); expect_tx(7, 1, 32'hD8, 32'h23222120, 4'hF);
    prog(0, 32'hC0, 32'hD0, 32'hE0, ctlw(0, 1, 1, 2, 2, 12'd1), cfgw(0, 0, 0, 0, 1));
    drain();
    chk("R9 tc from second descriptor only", 32'(tc_cnt[0]), 32'd1);
    chk("R8 chain end disables", 32'(chan_on[0]), 32'd0);

    // R10: error response
    clr_cnt();
    err_en = 1'b1; err_addr = 32'h0;
    expect_tx(10, 0, 32'h00, 0, 4'hF);
    prog(0, 32'h00, 32'h10, 0, ctlw(1, 1, 1, 2, 2, 12'd3), cfgw(0, 0, 0, 0, 1));
    drain();
    err_en = 1'b0;
    chk("R10 err pulse", 32'(err_cnt[0]), 32'd1);
    chk("R10 channel off", 32'(chan_on[0]), 32'd0);
    chk("R10 no tc", 32'(tc_cnt[0]), 32'd0);

    // R8: zero count start
    clr_cnt();
    prog(0, 32'h00, 32'h10, 0, ctlw(1, 1, 1, 2, 2, 12'd0), cfgw(0, 0, 0, 0, 1));
    drain();
    chk("R8 zero count disables", 32'(chan_on[0]), 32'd0);
    chk("R9 zero count tc", 32'(tc_cnt[0]), 32'd1);
    chk("R1 halted ch2 never served", 32'(chan_on[2]), 32'd1);

    finish_run();
  end
endmodule